// File: doc/BRIEF.md
# Receive descriptor ring engine

This block keeps a ring of receive descriptors in a small internal store and fills them as frames arrive. Each descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer pointer. Frames come in as a byte strobe, with a last-byte flag and an error code that is valid on the last byte. When a frame starts, the engine looks at the descriptor under its ring index. If that descriptor is owned by hardware, the engine counts the frame's bytes. At the last byte it writes the length and the error code back and releases the descriptor to software, all in one cycle. It then moves to the next entry, or back to the ring base after an entry that carries the wrap flag.

If a frame starts on a descriptor that software still owns, the engine raises a busy event, enters a halted state and discards that frame. It stays halted and discards whole frames until software issues a halt-clear command. Software reads and rewrites descriptors and the control registers through a simple register port. Buffer data movement is not part of this block.

Register map (word addresses on `reg_addr`):
- 0x00 to 0x1F: descriptor words. Bits [4:1] select the slot. Bit 0 = 0 selects the word {status, length}, with status in bits [31:16] and length in bits [15:0]. Bit 0 = 1 selects the buffer pointer.
- 0x20: ring base.
- 0x21: receive status. Read: bit 0 is the halted flag. Write: bit 0 = 1 clears the halt.
- 0x22: event. Bit 0 is busy, write-one-to-clear.
- 0x23: current ring index (read-only).

Status word bits:
- bit 15: empty (hardware owned)
- bit 13: wrap
- bits [2:0]: error code

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, the ring index is 0, the halted flag and the busy event are 0, and every descriptor word reads 0.
- R2: A register-port write to a descriptor word is read back unchanged, at the address mapping given above.
- R3: A frame that starts on a descriptor with status bit 15 set updates that descriptor in one cycle. The length becomes the number of bytes received, FCS included. Status bits [2:0] take the frame's error code. Bit 15 is cleared, the remaining status bits keep their value, and the buffer pointer is unchanged.
- R4: After each written-back descriptor, the ring index goes back to the ring base if status bit 13 of that descriptor was set. Otherwise it moves to the next slot, rolling from DEPTH-1 to 0.
- R5: A frame that starts on a descriptor with bit 15 clear sets the busy event and the halted flag. No descriptor is written and the ring index does not move.
- R6: While halted, incoming frames are discarded whole. No descriptor changes and the index holds.
- R7: Writing 1 to bit 0 of register 0x21 clears the halted flag. If a frame is in progress at that moment, the rest of that frame is still discarded, and the next frame is stored normally.
- R8: The busy event is cleared only by writing 1 to bit 0 of register 0x22. Writing 0 leaves it set, and clearing it does not end the halt.
- R9: Writing register 0x20 sets both the ring base and the current ring index to the written slot number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | One received byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| rx_err | input | 3 | Frame error code, valid with rx_last |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_halted | output | 1 | Engine is halted |
| rx_busy_evt | output | 1 | Busy event pending |
| ring_idx | output | IDX_W | Current ring index |
| desc_done | output | 1 | Pulse: a descriptor was written back |

## Verification
The fill path is driven with frames of several lengths and error codes on consecutive slots. This separates a correct byte count and error field from off-by-one counts and from status bits that get clobbered. A ring with the wrap flag on its last entry is run once with base 0 and once with a moved base, which tells a return to the ring base apart from a plain roll to slot 0. Ownership is tested by reusing a slot that software has not returned; this must halt without touching memory. A halt-clear issued in the middle of a frame shows whether the engine wrongly resumes inside that frame. The event register is written with both 0 and 1 to tell write-one-to-clear apart from a plain write.

// File: rtl/rxr_pkg.sv
// Shared constants for the receive descriptor ring engine.
// Assumes a 6-bit word address port and at most 16 descriptors.
package rxr_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = 16;
    localparam int ERR_W     = 3;
    localparam int SLOT_W    = 4;
    localparam int ST_EMPTY  = 15;
    localparam int ST_WRAP   = 13;

    typedef enum logic [1:0] {
        CTL_BASE  = 2'd0,
        CTL_RSTAT = 2'd1,
        CTL_EVENT = 2'd2,
        CTL_INDEX = 2'd3
    } ctl_reg_e;
endpackage

// File: rtl/rxr_desc_mem.sv
// Descriptor store: status, length and pointer per slot.
// Software reads and writes whole words. The hardware write-back updates
// length, error field and empty flag together, and takes priority over a
// software write to the same status/length word in the same cycle.
// Assumes hw_idx < DEPTH.
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic              sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0]  hw_idx,
    output logic [HALF_W-1:0] hw_status,
    input  logic              wb_en,
    input  logic [HALF_W-1:0] wb_len,
    input  logic [ERR_W-1:0]  wb_err
);
    logic [HALF_W-1:0] stat_q [DEPTH];
    logic [HALF_W-1:0] len_q  [DEPTH];
    logic [DATA_W-1:0] ptr_q  [DEPTH];

    // Storage update: hardware write-back first, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stat_q[i] <= '0;
                len_q[i]  <= '0;
                ptr_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wb_en && hw_idx == IDX_W'(i)) begin
                    stat_q[i] <= {1'b0, stat_q[i][ST_EMPTY-1:ERR_W], wb_err};
                    len_q[i]  <= wb_len;
                end else if (sw_wr && !sw_sel && sw_slot == SLOT_W'(i)) begin
                    stat_q[i] <= sw_wdata[DATA_W-1:HALF_W];
                    len_q[i]  <= sw_wdata[HALF_W-1:0];
                end
                if (sw_wr && sw_sel && sw_slot == SLOT_W'(i))
                    ptr_q[i] <= sw_wdata;
            end
        end
    end

    // Software read mux; slots beyond DEPTH read as zero.
    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sw_slot == SLOT_W'(i))
                sw_rdata = sw_sel ? ptr_q[i] : {stat_q[i], len_q[i]};
    end

    // Status of the slot under the ring index.
    always_comb begin
        hw_status = '0;
        for (int i = 0; i < DEPTH; i++)
            if (hw_idx == IDX_W'(i))
                hw_status = stat_q[i];
    end

    // R3
    wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (stat_q[$past(hw_idx)][ST_EMPTY] == 1'b0 &&
                   len_q[$past(hw_idx)] == $past(wb_len)));
endmodule

// File: rtl/rxr_frame_ctl.sv
// Frame controller: at frame start it claims the current descriptor or
// discards the frame, counts the bytes of a claimed frame, and issues the
// write-back on the last byte. A discarded frame is dropped to its end,
// even if the halt is lifted in the middle of it.
module rxr_frame_ctl
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_last,
    input  logic [ERR_W-1:0]  byte_err,
    input  logic              halted,
    input  logic              desc_empty,
    output logic              blocked,
    output logic              wb_en,
    output logic [HALF_W-1:0] wb_len,
    output logic [ERR_W-1:0]  wb_err
);
    logic              fill_q, drop_q;
    logic [HALF_W-1:0] cnt_q;
    logic              start, accept, discard;
    logic [HALF_W-1:0] cnt_inc;

    // Frame-start decisions and write-back signals.
    always_comb begin
        start   = byte_vld && !fill_q && !drop_q;
        accept  = start && !halted && desc_empty;
        discard = start && !accept;
        blocked = start && !halted && !desc_empty;
        cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        wb_en   = byte_vld && byte_last && (accept || fill_q);
        wb_len  = accept ? HALF_W'(1) : cnt_inc;
        wb_err  = byte_err;
    end

    // Frame state and saturating byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
            drop_q <= 1'b0;
            cnt_q  <= '0;
        end else if (byte_vld) begin
            if (accept)      cnt_q <= HALF_W'(1);
            else if (fill_q) cnt_q <= cnt_inc;
            if (byte_last) begin
                fill_q <= 1'b0;
                drop_q <= 1'b0;
            end else if (accept) begin
                fill_q <= 1'b1;
            end else if (discard) begin
                drop_q <= 1'b1;
            end
        end
    end

    // R6
    drop_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> !wb_en);

    // R7
    drop_until_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && !(byte_vld && byte_last)) |=> drop_q);
endmodule

// File: rtl/rxr_ring_ptr.sv
// Ring pointer plus halt/busy state. The index follows write-backs and
// returns to the base after a wrap-flagged slot. The halt is set by a
// blocked frame start and cleared only by the halt-clear command. The
// busy event is write-one-to-clear, and a new set wins over a clear.
module rxr_ring_ptr #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             cur_wrap,
    input  logic             base_wr,
    input  logic [IDX_W-1:0] base_val,
    input  logic             blocked,
    input  logic             halt_clr,
    input  logic             busy_w1c,
    output logic [IDX_W-1:0] cur_idx,
    output logic             halted,
    output logic             busy
);
    logic [IDX_W-1:0] base_q, idx_q;
    logic             base_ok;

    assign base_ok = (base_val <= IDX_W'(DEPTH - 1));
    assign cur_idx = idx_q;

    // Ring base and current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (base_wr && base_ok) begin
            base_q <= base_val;
            idx_q  <= base_val;
        end else if (adv) begin
            if (cur_wrap)                        idx_q <= base_q;
            else if (idx_q == IDX_W'(DEPTH - 1)) idx_q <= '0;
            else                                 idx_q <= idx_q + 1'b1;
        end
    end

    // Halt flag and busy event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
            busy   <= 1'b0;
        end else begin
            if (blocked)       halted <= 1'b1;
            else if (halt_clr) halted <= 1'b0;
            if (blocked)       busy   <= 1'b1;
            else if (busy_w1c) busy   <= 1'b0;
        end
    end

    // R4
    idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> $past(adv || base_wr));

    // R5
    halt_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> busy);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !halt_clr) |=> halted);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_w1c) |=> busy);
endmodule

// File: rtl/rx_ring_engine.sv
// Receive descriptor ring engine top: register decode plus the store,
// frame controller and ring pointer. Assumes DEPTH between 2 and 16.
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld,
    input  logic              rx_last,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_halted,
    output logic              rx_busy_evt,
    output logic [IDX_W-1:0]  ring_idx,
    output logic              desc_done
);
    logic              is_ctl, ctl_hit;
    ctl_reg_e          ctl_sel;
    logic [DATA_W-1:0] mem_rdata;
    logic [HALF_W-1:0] cur_status;
    logic              blocked, wb_en;
    logic [HALF_W-1:0] wb_len;
    logic [ERR_W-1:0]  wb_err;
    logic              base_wr, halt_clr, busy_w1c;

    // Address decode for the control registers.
    always_comb begin
        is_ctl   = reg_addr[ADDR_W-1];
        ctl_hit  = is_ctl && (reg_addr[ADDR_W-2:2] == '0);
        ctl_sel  = ctl_reg_e'(reg_addr[1:0]);
        base_wr  = reg_wr && ctl_hit && ctl_sel == CTL_BASE;
        halt_clr = reg_wr && ctl_hit && ctl_sel == CTL_RSTAT && reg_wdata[0];
        busy_w1c = reg_wr && ctl_hit && ctl_sel == CTL_EVENT && reg_wdata[0];
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        if (!is_ctl) reg_rdata = mem_rdata;
        else if (ctl_hit) begin
            case (ctl_sel)
                CTL_RSTAT: reg_rdata = DATA_W'(rx_halted);
                CTL_EVENT: reg_rdata = DATA_W'(rx_busy_evt);
                CTL_INDEX: reg_rdata = DATA_W'(ring_idx);
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign desc_done = wb_en;

    rxr_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(reg_wr && !is_ctl), .sw_slot(reg_addr[SLOT_W:1]),
        .sw_sel(reg_addr[0]), .sw_wdata(reg_wdata), .sw_rdata(mem_rdata),
        .hw_idx(ring_idx), .hw_status(cur_status),
        .wb_en(wb_en), .wb_len(wb_len), .wb_err(wb_err)
    );

    rxr_frame_ctl u_frame (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(rx_vld), .byte_last(rx_last), .byte_err(rx_err),
        .halted(rx_halted), .desc_empty(cur_status[ST_EMPTY]),
        .blocked(blocked), .wb_en(wb_en), .wb_len(wb_len), .wb_err(wb_err)
    );

    rxr_ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .adv(wb_en), .cur_wrap(cur_status[ST_WRAP]),
        .base_wr(base_wr), .base_val(reg_wdata[IDX_W-1:0]),
        .blocked(blocked), .halt_clr(halt_clr), .busy_w1c(busy_w1c),
        .cur_idx(ring_idx), .halted(rx_halted), .busy(rx_busy_evt)
    );

    // R6
    halt_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halted |-> !desc_done);
endmodule

// File: tb/sim_rx_ring_engine.sv
`timescale 1ns/1ps
module sim_rx_ring_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0, rx_last = 1'b0;
    logic [2:0]  rx_err = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_halted, rx_busy_evt, desc_done;
    logic [1:0]  ring_idx;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_ring_engine #(.DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_last(rx_last),
        .rx_err(rx_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_halted(rx_halted),
        .rx_busy_evt(rx_busy_evt), .ring_idx(ring_idx), .desc_done(desc_done)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic bytes(input int n, input bit end_it, input logic [2:0] e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_last = end_it && (i == n - 1); rx_err = e;
        end
        @(negedge clk); rx_vld = 1'b0; rx_last = 1'b0; rx_err = '0;
    endtask

    task automatic chk_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        chk_rd("R1 index", 6'h23, 0);
        chk_rd("R1 halted", 6'h21, 0);
        chk_rd("R1 busy", 6'h22, 0);
        chk_rd("R1 desc0", 6'h00, 0);
    endtask

    task automatic t_regport;
        wr(6'h01, 32'h1000_0000);
        wr(6'h03, 32'hDEAD_BEEF);
        chk_rd("R2 ptr1", 6'h03, 32'hDEAD_BEEF);
        wr(6'h00, 32'h8000_0000); wr(6'h02, 32'h8000_0000);
        wr(6'h04, 32'h8000_0000); wr(6'h06, 32'hA000_0000);
        chk_rd("R2 desc3 word", 6'h06, 32'hA000_0000);
    endtask

    task automatic t_fill;
        bytes(64, 1, 3'd0);
        chk_rd("R3 desc0 len", 6'h00, 32'h0000_0040);
        chk_rd("R3 ptr0 kept", 6'h01, 32'h1000_0000);
        chk_rd("R4 index 1", 6'h23, 1);
        bytes(5, 1, 3'b101);
        chk_rd("R3 desc1 err", 6'h02, 32'h0005_0005);
    endtask

    task automatic t_wrap;
        bytes(20, 1, 3'd0);
        bytes(33, 1, 3'd0);
        chk_rd("R3 desc3 wrap kept", 6'h06, 32'h2000_0021);
        chk_rd("R4 back to base 0", 6'h23, 0);
    endtask

    task automatic t_block;
        bytes(10, 1, 3'd0);
        chk(  "R5 halted", {31'b0, rx_halted}, 1);
        chk_rd("R5 busy", 6'h22, 1);
        chk_rd("R5 desc0 untouched", 6'h00, 32'h0000_0040);
        bytes(8, 1, 3'd2);
        chk_rd("R6 desc0 untouched", 6'h00, 32'h0000_0040);
        chk_rd("R6 index held", 6'h23, 0);
    endtask

    task automatic t_event;
        wr(6'h22, 0);
        chk_rd("R8 write 0 keeps busy", 6'h22, 1);
        wr(6'h22, 1);
        chk_rd("R8 w1c clears busy", 6'h22, 0);
        chk_rd("R8 still halted", 6'h21, 1);
    endtask

    task automatic t_resume;
        wr(6'h00, 32'h8000_0000);
        bytes(3, 0, 3'd0);
        wr(6'h21, 1);
        chk_rd("R7 halt cleared", 6'h21, 0);
        bytes(3, 1, 3'd0);
        chk_rd("R7 mid-frame dropped", 6'h00, 32'h8000_0000);
        chk_rd("R7 index held", 6'h23, 0);
        bytes(7, 1, 3'd0);
        chk_rd("R7 next frame stored", 6'h00, 32'h0000_0007);
        chk_rd("R7 index 1", 6'h23, 1);
    endtask

    task automatic t_base;
        wr(6'h20, 2);
        chk_rd("R9 index at base", 6'h23, 2);
        wr(6'h04, 32'h8000_0000); wr(6'h06, 32'hA000_0000);
        bytes(9, 1, 3'd0);
        chk_rd("R9 desc2 filled", 6'h04, 32'h0000_0009);
        bytes(12, 1, 3'd0);
        chk_rd("R9 desc3 filled", 6'h06, 32'h2000_000C);
        chk_rd("R4 wrap to base 2", 6'h23, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regport();
        t_fill();
        t_wrap();
        t_block();
        t_event();
        t_resume();
        t_base();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule